// File: doc/BRIEF.md
# Random Number Generator Controller

A memory-mapped random word source with a 32-bit register interface. Software runs a fixed sequence. It starts a self-test. Once that has completed, it starts a seed generation. After a clean seed, an internal pseudo-random core based on a linear feedback shift register pushes one 32-bit word per cycle into a 16-entry output FIFO until the FIFO is full. Software pops words through a read port and watches the FIFO level in a status register.

Each sequence step raises its own done flag. Detailed failure causes collect in an error register, and a summary error flag in the status register reflects them. A single interrupt line goes high on any done or error event that its control mask bit does not suppress. Software clears the done flags and the error causes with write-one command bits. A seed attempt that fails only the statistical check can be retried. Any other cause stops FIFO filling until software clears it. A test input forces the statistical failure on the next seed attempt, so the retry path can be exercised.

Top module: `rand_gen_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the status, error and control registers read zero, the FIFO level is 0 and `irq` is low.
- R2: The command register sits at byte offset 0x04. Its bits are write-one actions and the register always reads back as zero: bit 0 starts a self-test, bit 1 starts a seed, bit 4 clears the done flags and bit 5 clears the error register.
- R3: A self-test takes ST_CYCLES cycles. Status bit 4 (status at offset 0x0C) reads 0 in the cycle before the last one and 1 from the cycle after the command edge plus ST_CYCLES.
- R4: A seed command is ignored until a self-test has completed since reset. Once accepted, status bit 5 sets SEED_CYCLES cycles after the command edge.
- R5: After a clean seed, the FIFO level (status bits 11:8) rises by one per cycle, starting the cycle after seed done. The level field saturates at 15 while all 16 entries are full.
- R6: Reads of the FIFO port (offset 0x14) pop non-zero words, and consecutive words differ.
- R7: A FIFO read while the FIFO is empty returns zero and sets error bit 8 (error register at offset 0x10) and status bit 16. While any error bit other than bit 3 is set, filling stays stopped even after a good seed, and it resumes when the error is cleared.
- R8: When the forcing input is high as a seed is accepted, that seed ends with the error register equal to 0x08 and no filling. Filling resumes once the error is cleared on a later good seed.
- R9: `irq` is high when a done flag is set and control bit 5 (offset 0x08) is clear, or when any error bit is set and control bit 6 is clear.
- R10: Command bit 4 clears both done flags. Command bit 5 zeroes the error register and the summary flag. Writing both together drops `irq`.
- R11: A start command issued while a self-test or seed is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the FIFO at its offset) |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| inj_stat_fail | input | 1 | Test hook: force a statistical failure on the next accepted seed |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a fatal error while the generator is seeded. Once seeded, the FIFO refills every cycle, so it cannot be read empty. The bench first forces a statistical failure so that the seeded state drops. It drains the FIFO and reads it once more to raise the underflow cause. It then seeds again without clearing, which leaves a good seed sitting behind a fatal error and shows that filling stays stopped until the error is cleared.

// File: rtl/rgc_pkg.sv
// Shared register offsets and bit positions for the random generator controller.
package rgc_pkg;
    localparam logic [7:0] OFF_CMD  = 8'h04;
    localparam logic [7:0] OFF_CTL  = 8'h08;
    localparam logic [7:0] OFF_STAT = 8'h0C;
    localparam logic [7:0] OFF_ERR  = 8'h10;
    localparam logic [7:0] OFF_FIFO = 8'h14;

    localparam int CMD_TEST    = 0;
    localparam int CMD_SEED    = 1;
    localparam int CMD_CLR_INT = 4;
    localparam int CMD_CLR_ERR = 5;

    localparam int CTL_MASK_DONE = 5;
    localparam int CTL_MASK_ERR  = 6;

    localparam int ST_TEST_DONE = 4;
    localparam int ST_SEED_DONE = 5;
    localparam int ST_LVL_LO    = 8;
    localparam int LVL_W        = 4;
    localparam int ST_ERR_SUM   = 16;

    localparam int ERR_OSC   = 1;
    localparam int ERR_STAT  = 3;
    localparam int ERR_KEY   = 6;
    localparam int ERR_UNDER = 8;
endpackage

// File: rtl/rgc_lfsr.sv
// Free-running Galois LFSR standing in for the entropy source.
// Assumes INIT is non-zero, so the state never reaches zero.
module rgc_lfsr #(
    parameter int          W    = 32,
    parameter logic [W-1:0] TAPS = 32'h8020_0003,
    parameter logic [W-1:0] INIT = 32'h1ACE_B00C
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state
);
    // Advance one step every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        state <= INIT;
        else if (state[0]) state <= (state >> 1) ^ TAPS;
        else               state <= state >> 1;
    end
endmodule

// File: rtl/rgc_fifo.sv
// Output word FIFO with occupancy count. A pop while empty is ignored
// and the read data is zero; the caller must not push when full.
module rgc_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [W-1:0]      din,
    input  logic              pop,
    output logic [W-1:0]      dout,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic              full,
    output logic              empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = empty ? '0 : mem[rd_ptr];

    // Store the pushed word.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Maintain pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/rgc_seq.sv
// Sequencer for self-test and seed generation. Starts are accepted only
// when idle; a seed also needs a completed self-test since reset.
// Assumes ST_CYCLES and SEED_CYCLES are at least 2.
module rgc_seq #(
    parameter int ST_CYCLES   = 64,
    parameter int SEED_CYCLES = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_test,
    input  logic go_seed,
    input  logic inj_fail,
    input  logic clr_done,
    output logic st_busy,
    output logic sd_busy,
    output logic st_done,
    output logic sd_done,
    output logic seeded,
    output logic stat_fail
);
    localparam int MAXC  = (ST_CYCLES > SEED_CYCLES) ? ST_CYCLES : SEED_CYCLES;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] ST_LAST = CNT_W'(ST_CYCLES - 1);
    localparam logic [CNT_W-1:0] SD_LAST = CNT_W'(SEED_CYCLES - 1);

    logic [CNT_W-1:0] cnt;
    logic             st_ok, inj_q;
    logic             take_test, take_seed, st_end, sd_end;

    assign take_test = go_test && !st_busy && !sd_busy;
    assign take_seed = go_seed && !st_busy && !sd_busy && st_ok && !go_test;
    assign st_end    = st_busy && (cnt == ST_LAST);
    assign sd_end    = sd_busy && (cnt == SD_LAST);
    assign stat_fail = sd_end && inj_q;

    // Run the operation counter and busy flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            st_busy <= 1'b0;
            sd_busy <= 1'b0;
            inj_q   <= 1'b0;
        end else if (take_test) begin
            cnt     <= '0;
            st_busy <= 1'b1;
        end else if (take_seed) begin
            cnt     <= '0;
            sd_busy <= 1'b1;
            inj_q   <= inj_fail;
        end else if (st_end) begin
            st_busy <= 1'b0;
        end else if (sd_end) begin
            sd_busy <= 1'b0;
        end else if (st_busy || sd_busy) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Done flags: clear on command, set on completion (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_done <= 1'b0;
            sd_done <= 1'b0;
        end else begin
            st_done <= (st_done && !clr_done) || st_end;
            sd_done <= (sd_done && !clr_done) || sd_end;
        end
    end

    // Track self-test completion and a clean seed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_ok  <= 1'b0;
            seeded <= 1'b0;
        end else begin
            if (st_end)         st_ok  <= 1'b1;
            if (take_seed)      seeded <= 1'b0;
            else if (sd_end)    seeded <= !inj_q;
        end
    end
endmodule

// File: rtl/rand_gen_ctrl.sv
// Random number generator controller top: register decode, error and
// interrupt logic, sequencer, LFSR core and output FIFO.
// Assumes the bus never issues a read and a write in the same cycle.
module rand_gen_ctrl
    import rgc_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int FIFO_DEPTH  = 16,
    parameter int ST_CYCLES   = 64,
    parameter int SEED_CYCLES = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              inj_stat_fail,
    output logic              irq
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
    localparam logic [CNT_W-1:0] LVL_CAP = CNT_W'((1 << LVL_W) - 1);
    localparam logic [31:0] FATAL_MASK = ~(32'h1 << ERR_STAT);

    logic             wr_cmd, wr_ctl, rd_fifo, rd_hit;
    logic             mask_done_q, mask_err_q;
    logic [31:0]      err_q;
    logic             st_busy, sd_busy, st_done, sd_done, seeded, stat_fail;
    logic [31:0]      rnd_word, fifo_dout, stat_word;
    logic [CNT_W-1:0] fifo_cnt;
    logic             fifo_full, fifo_empty, push, underflow;
    logic [LVL_W-1:0] lvl;
    logic             wdata_unused;

    assign wdata_unused = ^bus_wdata;
    assign wr_cmd    = bus_wr && (bus_addr == ADDR_W'(OFF_CMD));
    assign wr_ctl    = bus_wr && (bus_addr == ADDR_W'(OFF_CTL));
    assign rd_fifo   = bus_rd && (bus_addr == ADDR_W'(OFF_FIFO));
    assign rd_hit    = rd_fifo;
    assign underflow = rd_fifo && fifo_empty;
    assign push      = seeded && ((err_q & FATAL_MASK) == '0) && !fifo_full;

    rgc_seq #(.ST_CYCLES(ST_CYCLES), .SEED_CYCLES(SEED_CYCLES)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_test  (wr_cmd && bus_wdata[CMD_TEST]),
        .go_seed  (wr_cmd && bus_wdata[CMD_SEED]),
        .inj_fail (inj_stat_fail),
        .clr_done (wr_cmd && bus_wdata[CMD_CLR_INT]),
        .st_busy  (st_busy),
        .sd_busy  (sd_busy),
        .st_done  (st_done),
        .sd_done  (sd_done),
        .seeded   (seeded),
        .stat_fail(stat_fail)
    );

    rgc_lfsr #(.W(32)) u_lfsr (
        .clk  (clk),
        .rst_n(rst_n),
        .state(rnd_word)
    );

    rgc_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (push),
        .din  (rnd_word),
        .pop  (rd_hit),
        .dout (fifo_dout),
        .count(fifo_cnt),
        .full (fifo_full),
        .empty(fifo_empty)
    );

    // Hold the interrupt mask bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_done_q <= 1'b0;
            mask_err_q  <= 1'b0;
        end else if (wr_ctl) begin
            mask_done_q <= bus_wdata[CTL_MASK_DONE];
            mask_err_q  <= bus_wdata[CTL_MASK_ERR];
        end
    end

    // Collect error causes; a clear command runs before new causes land.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
        end else begin
            err_q <= ((wr_cmd && bus_wdata[CMD_CLR_ERR]) ? '0 : err_q)
                   | (32'(stat_fail) << ERR_STAT)
                   | (32'(underflow) << ERR_UNDER);
        end
    end

    // Saturate the level field at its largest code.
    assign lvl = (fifo_cnt >= LVL_CAP) ? LVL_CAP[LVL_W-1:0] : fifo_cnt[LVL_W-1:0];

    // Assemble the status word.
    always_comb begin
        stat_word = '0;
        stat_word[ST_TEST_DONE] = st_done;
        stat_word[ST_SEED_DONE] = sd_done;
        stat_word[ST_LVL_LO +: LVL_W] = lvl;
        stat_word[ST_ERR_SUM] = |err_q;
    end

    // Read data mux; the command register always reads zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == ADDR_W'(OFF_CTL)) begin
                bus_rdata[CTL_MASK_DONE] = mask_done_q;
                bus_rdata[CTL_MASK_ERR]  = mask_err_q;
            end else if (bus_addr == ADDR_W'(OFF_STAT)) begin
                bus_rdata = stat_word;
            end else if (bus_addr == ADDR_W'(OFF_ERR)) begin
                bus_rdata = err_q;
            end else if (bus_addr == ADDR_W'(OFF_FIFO)) begin
                bus_rdata = fifo_dout;
            end
        end
    end

    // Interrupt: unmasked done or unmasked error.
    assign irq = ((st_done || sd_done) && !mask_done_q) || ((|err_q) && !mask_err_q);
endmodule

// File: rtl/rgc_checker.sv
// Property checker for rand_gen_ctrl, attached by bind.
module rgc_checker
    import rgc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 5,
    parameter int DEPTH  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              irq,
    input logic              mask_done,
    input logic              mask_err,
    input logic [31:0]       err_q,
    input logic [CNT_W-1:0]  fifo_cnt,
    input logic              busy
);
    AST_CMD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(OFF_CMD)) |-> bus_rdata == '0); // R2

    AST_LEVEL_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(OFF_STAT) && fifo_cnt == CNT_W'(DEPTH))
        |-> bus_rdata[ST_LVL_LO +: LVL_W] == '1); // R5

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(OFF_FIFO) && fifo_cnt == '0) |-> bus_rdata == '0); // R7

    AST_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == ADDR_W'(OFF_FIFO) && fifo_cnt == '0)
        |=> err_q[ERR_UNDER]); // R7

    AST_MASKS_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_done && mask_err) |-> !irq); // R9

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd && !busy && bus_addr == ADDR_W'(OFF_CMD)
         && bus_wdata[CMD_CLR_INT] && bus_wdata[CMD_CLR_ERR])
        |=> (err_q == '0 && !irq)); // R10
endmodule

bind rand_gen_ctrl rgc_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEPTH(FIFO_DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq      (irq),
    .mask_done(mask_done_q),
    .mask_err (mask_err_q),
    .err_q    (err_q),
    .fifo_cnt (fifo_cnt),
    .busy     (st_busy || sd_busy)
);

// File: tb/rand_gen_ctrl_bench.sv
// Directed bench for rand_gen_ctrl: one task per scenario.
module rand_gen_ctrl_bench;
    localparam int ST  = 8;
    localparam int SD  = 12;
    localparam logic [7:0] A_CMD = 8'h04, A_CTL = 8'h08, A_STAT = 8'h0C,
                           A_ERR = 8'h10, A_FIFO = 8'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, inj = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        irq;
    int          n_run = 0, n_fail = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    rand_gen_ctrl #(.ADDR_W(8), .FIFO_DEPTH(16), .ST_CYCLES(ST), .SEED_CYCLES(SD))
    u_rand_gen_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .inj_stat_fail(inj), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_STAT, v); chk("R1 status", v, 32'h0);
        rd(A_ERR, v);  chk("R1 error", v, 32'h0);
        rd(A_CTL, v);  chk("R1 control", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_underflow();
        logic [31:0] v;
        rd(A_FIFO, v); chk("R7 empty read", v, 32'h0);
        rd(A_ERR, v);  chk("R7 underflow bit", v, 32'h100);
        rd(A_STAT, v); chk("R7 summary bit16", v[16], 1'b1);
        chk("R9 irq on error", {31'b0, irq}, 32'h1);
        wr(A_CTL, 32'h40);
        chk("R9 error masked", {31'b0, irq}, 32'h0);
        wr(A_CTL, 32'h0);
        wr(A_CMD, 32'h30);
        rd(A_ERR, v);  chk("R10 error cleared", v, 32'h0);
        chk("R10 irq dropped", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_seed_early();
        logic [31:0] v;
        wr(A_CMD, 32'h2);
        idle(SD + 4);
        rd(A_STAT, v); chk("R4 seed before self-test ignored", v, 32'h0);
    endtask

    task automatic t_selftest();
        logic [31:0] v;
        wr(A_CMD, 32'h1);
        idle(ST - 1);
        rd(A_STAT, v); chk("R3 not yet done", v[4], 1'b0);
        rd(A_STAT, v); chk("R3 done", v, 32'h10);
        chk("R9 irq on done", {31'b0, irq}, 32'h1);
        rd(A_CMD, v);  chk("R2 command reads zero", v, 32'h0);
        wr(A_CTL, 32'h20);
        chk("R9 done masked", {31'b0, irq}, 32'h0);
        rd(A_CTL, v);  chk("R9 control readback", v, 32'h20);
        wr(A_CTL, 32'h0);
        wr(A_CMD, 32'h10);
        rd(A_STAT, v); chk("R10 done cleared", v, 32'h0);
    endtask

    task automatic t_seed_busy();
        logic [31:0] v;
        wr(A_CMD, 32'h2);
        wr(A_CMD, 32'h1);
        idle(SD - 2);
        rd(A_STAT, v); chk("R4 seed not yet done", v, 32'h0);
        rd(A_STAT, v); chk("R4 seed done", v, 32'h20);
        rd(A_STAT, v); chk("R5 level 1", v[11:8], 4'd1);
        rd(A_STAT, v); chk("R5 level 2", v[11:8], 4'd2);
        idle(20);
        rd(A_STAT, v); chk("R11 self-test during seed ignored", v[4], 1'b0);
        chk("R5 full level saturates", v[11:8], 4'hF);
    endtask

    task automatic t_words();
        logic [31:0] a, b, v;
        rd(A_FIFO, a);
        rd(A_FIFO, b);
        chk("R6 word nonzero", {31'b0, a != 0}, 32'h1);
        chk("R6 words differ", {31'b0, a != b}, 32'h1);
        rd(A_ERR, v); chk("R6 no error on reads", v, 32'h0);
    endtask

    task automatic t_stat_retry();
        logic [31:0] v;
        idle(4);
        wr(A_CMD, 32'h10);
        inj = 1'b1;
        wr(A_CMD, 32'h2);
        inj = 1'b0;
        idle(SD + 2);
        rd(A_ERR, v);  chk("R8 statistical only", v, 32'h08);
        rd(A_STAT, v); chk("R8 seed done with error", {v[16], v[5]}, 2'b11);
        for (int i = 0; i < 16; i++) rd(A_FIFO, v);
        idle(5);
        rd(A_STAT, v); chk("R8 no fill after failed seed", v[11:8], 4'd0);
        rd(A_FIFO, v);
        rd(A_ERR, v);  chk("R7 underflow added", v, 32'h108);
        wr(A_CMD, 32'h2);
        idle(SD + 6);
        rd(A_STAT, v); chk("R7 fatal error blocks fill", v[11:8], 4'd0);
        wr(A_CMD, 32'h20);
        idle(20);
        rd(A_STAT, v); chk("R8 retry fills after clear", v[11:8], 4'hF);
        rd(A_ERR, v);  chk("R10 clear error", v, 32'h0);
        wr(A_CMD, 32'h30);
        chk("R10 both clears drop irq", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_underflow();
        t_seed_early();
        t_selftest();
        t_seed_busy();
        t_words();
        t_stat_retry();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule